// File: doc/BRIEF.md
# Augmented binary32 multiplier (head/tail product split)

This unit multiplies two binary32 operands and returns the exact product as two single-precision values. The head is the product rounded to the nearest representable value. A tie goes to the value of smaller magnitude. The tail is what remains of the exact product after the head is taken away. Software that extends precision (double-word arithmetic, compensated and order-independent summation) uses the pair as an error-free transformation. The unit also raises invalid, overflow, underflow and inexact flags for each result.

The datapath forms the full double-width significand product. It normalizes the product and rounds the upper half into the head. The remainder is renormalized into the tail. Any part of the result whose weight falls below the smallest subnormal magnitude is discarded. Infinities, zeros, NaNs and overflow bypass the datapath and give both outputs the same value. One operand pair is accepted per cycle, and its result appears one clock edge later.

Top module: `twin_product_unit`

## Requirements
- R1: The head is the exact product rounded to nearest. When the exact product lies halfway between two representable values, the head is the one of smaller magnitude.
- R2: For a finite result whose tail lies in the normal range, the tail equals the exact product minus the head, with no flags raised. A zero tail carries the sign of the product.
- R3: When the rounded head exceeds the largest finite value, head and tail are both infinity with sign (sign_a XOR sign_b), and the overflow and inexact flags are set.
- R4: A product that involves an infinity and a non-zero, non-NaN operand gives the same infinity in both outputs, with sign (sign_a XOR sign_b), and raises no flags.
- R5: A product that involves a zero and a finite operand gives the same zero in both outputs, with sign (sign_a XOR sign_b). For example, +0 × −0 gives 0x80000000 and −0 × −0 gives 0x00000000.
- R6: If an operand is a NaN, both outputs are that NaN with fraction bit 22 set. The first operand wins when both are NaN. The invalid flag is raised only if an operand is a signaling NaN, that is, a NaN with fraction bit 22 clear.
- R7: Zero times infinity gives 0x7FC00000 in both outputs and raises invalid.
- R8: Result bits weighted below 2^-149 are lost. A subnormal head is rounded under the rule of R1, and tail bits below that weight are truncated. Any such loss sets inexact.
- R9: Underflow is raised exactly when R8 discards bits. An exactly representable subnormal product raises no flag.
- R10: `out_valid` rises one clock edge after an accepted `in_valid`. The outputs hold their value between results. A synchronous reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair is presented this cycle |
| op_a | input | 32 | First binary32 operand |
| op_b | input | 32 | Second binary32 operand |
| out_valid | output | 1 | Result registers hold a new result |
| head | output | 32 | Rounded product |
| tail | output | 32 | Exact remainder of the product |
| flag_invalid | output | 1 | Invalid operation |
| flag_overflow | output | 1 | Head overflowed |
| flag_underflow | output | 1 | Bits lost below the subnormal range |
| flag_inexact | output | 1 | Head plus tail differs from the exact product |

## Verification
In one result, rounding the head and forming the tail interact in two ways. A tie that rounds toward zero leaves a positive tail of exactly half a unit in the last place. A round-up flips the tail's sign. The bench provokes ties with a significand of 1.5 times one of 1 plus one ulp. It provokes round-ups with operands whose two low significand bits are set, and it compares each head/tail pair against an integer model of the exact product. In the tiny range, head rounding and tail truncation also meet in one cycle. A smallest-subnormal operand times one half produces a subnormal tie together with the inexact and underflow flags. This is checked against hand-computed encodings.

// File: rtl/tpu_pkg.sv
package tpu_pkg;
    parameter int EW = 8;
    parameter int MW = 23;
    localparam int FW   = 1 + EW + MW;
    localparam int P    = MW + 1;
    localparam int PW   = 2 * P;
    localparam int VW   = PW + P;
    localparam int BIAS = (1 << (EW - 1)) - 1;
    localparam int EMAX_F = (1 << EW) - 1;

    localparam logic [FW-1:0] QNAN_DEF = {1'b0, {EW{1'b1}}, 1'b1, {(MW-1){1'b0}}};

    typedef enum logic [2:0] {K_ZERO, K_FIN, K_INF, K_QNAN, K_SNAN} kind_t;

    typedef struct packed {
        logic           sgn;
        kind_t          kind;
        logic [EW-1:0]  exp_eff;
        logic [P-1:0]   sig;
        logic [FW-1:0]  raw;
    } opnd_t;

    typedef struct packed {
        logic [FW-1:0] head;
        logic [FW-1:0] tail;
        logic          inv;
        logic          ovf;
        logic          unf;
        logic          inx;
    } result_t;

    function automatic int lead_zeros(input logic [PW-1:0] v);
        int n;
        n = PW;
        for (int i = 0; i < PW; i++)
            if (v[i]) n = PW - 1 - i;
        return n;
    endfunction

    function automatic int msb_pos(input logic [PW-1:0] v);
        int m;
        m = 0;
        for (int i = 0; i < PW; i++)
            if (v[i]) m = i;
        return m;
    endfunction

    function automatic logic is_nan(input logic [FW-1:0] w);
        return (w[FW-2:MW] == {EW{1'b1}}) && (w[MW-1:0] != '0);
    endfunction
endpackage

// File: rtl/tpu_unpack.sv
module tpu_unpack
    import tpu_pkg::*;
(
    input  logic [FW-1:0] word,
    output opnd_t         op
);
    logic [EW-1:0] e;
    logic [MW-1:0] f;

    assign e = word[FW-2:MW];
    assign f = word[MW-1:0];

    always_comb begin
        op.sgn     = word[FW-1];
        op.raw     = word;
        op.exp_eff = e;
        op.sig     = {1'b1, f};
        op.kind    = K_FIN;
        if (e == '0) begin
            op.exp_eff = EW'(1);
            op.sig     = {1'b0, f};
            op.kind    = (f == '0) ? K_ZERO : K_FIN;
        end else if (e == {EW{1'b1}}) begin
            if (f == '0)        op.kind = K_INF;
            else if (f[MW-1])   op.kind = K_QNAN;
            else                op.kind = K_SNAN;
        end
    end
endmodule

// File: rtl/tpu_core.sv
module tpu_core
    import tpu_pkg::*;
(
    input  opnd_t   a,
    input  opnd_t   b,
    output result_t res
);
    logic          sgn;
    logic [PW-1:0] prod, pn;
    logic [VW-1:0] vfull, vsh;
    logic [P-1:0]  hm;
    logic [PW-1:0] rem;
    logic          stk, up, tlost, hloss, ovf;
    logic [P:0]    hmr;
    logic [PW-1:0] tm, tnorm, tfield;
    int            lz, he, d, hexp, k, te, q;
    logic [MW-1:0] hfrac;

    assign sgn  = a.sgn ^ b.sgn;
    assign prod = PW'(a.sig) * PW'(b.sig);

    always_comb begin
        lz    = lead_zeros(prod);
        pn    = prod << lz;
        he    = int'(a.exp_eff) + int'(b.exp_eff) - BIAS + 1 - lz;
        d     = (he < 1) ? (1 - he) : 0;
        vfull = {pn, {P{1'b0}}};
        vsh   = vfull >> d;
        stk   = |(vfull & ~({VW{1'b1}} << d));
        hm    = vsh[VW-1:PW];
        rem   = vsh[PW-1:0];
        up    = (rem > {1'b1, {(PW-1){1'b0}}}) ||
                ((rem == {1'b1, {(PW-1){1'b0}}}) && stk);
        hmr   = {1'b0, hm} + (P+1)'(up);
        hfrac = hmr[MW-1:0];
        if (he >= 1) begin
            hexp = hmr[P] ? he + 1 : he;
            if (hmr[P]) hfrac = '0;
        end else begin
            hexp = hmr[MW] ? 1 : 0;
        end
        ovf   = (hexp >= EMAX_F);
        hloss = (he < 1) && ((rem != '0) || stk);

        // tail: exact remainder of a normal-range head, truncated below 2^-149
        tm     = '0;
        tnorm  = '0;
        tfield = '0;
        tlost  = 1'b0;
        k      = 0;
        te     = 0;
        q      = 0;
        res.tail = {sgn, {(FW-1){1'b0}}};
        if (he >= 1) begin
            tm = up ? (PW'(1) << P) - PW'(pn[P-1:0]) : PW'(pn[P-1:0]);
            if (tm != '0) begin
                k  = msb_pos(tm);
                te = he - (MW + P) + k;
                if (te >= 1) begin
                    tnorm    = tm << (MW - k);
                    res.tail = {sgn ^ up, te[EW-1:0], tnorm[MW-1:0]};
                end else begin
                    q = P + 1 - he;
                    if (q > 0) begin
                        tfield = tm >> q;
                        tlost  = |(tm & ~({PW{1'b1}} << q));
                    end else begin
                        tfield = tm << (-q);
                    end
                    if (tfield != '0)
                        res.tail = {sgn ^ up, {EW{1'b0}}, tfield[MW-1:0]};
                end
            end
        end

        res.head = {sgn, hexp[EW-1:0], hfrac};
        res.inv  = 1'b0;
        res.ovf  = ovf;
        res.unf  = !ovf && (hloss || tlost);
        res.inx  = ovf || hloss || tlost;
        if (ovf) begin
            res.head = {sgn, {EW{1'b1}}, {MW{1'b0}}};
            res.tail = {sgn, {EW{1'b1}}, {MW{1'b0}}};
        end
    end
endmodule

// File: rtl/twin_product_unit.sv
module twin_product_unit
    import tpu_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [FW-1:0] op_a,
    input  logic [FW-1:0] op_b,
    output logic          out_valid,
    output logic [FW-1:0] head,
    output logic [FW-1:0] tail,
    output logic          flag_invalid,
    output logic          flag_overflow,
    output logic          flag_underflow,
    output logic          flag_inexact
);
    logic [FW-1:0] words [2];
    opnd_t         ops   [2];
    result_t       fin_r, nxt, r_q;
    logic          sgn, any_nan, any_inf, any_zero;
    logic [FW-1:0] nan_w, inf_w, zero_w;

    assign words[0] = op_a;
    assign words[1] = op_b;

    for (genvar g = 0; g < 2; g++) begin : g_unp
        tpu_unpack u_unp (.word(words[g]), .op(ops[g]));
    end

    tpu_core u_core (.a(ops[0]), .b(ops[1]), .res(fin_r));

    always_comb begin
        sgn      = ops[0].sgn ^ ops[1].sgn;
        any_nan  = (ops[0].kind inside {K_QNAN, K_SNAN}) || (ops[1].kind inside {K_QNAN, K_SNAN});
        any_inf  = (ops[0].kind == K_INF) || (ops[1].kind == K_INF);
        any_zero = (ops[0].kind == K_ZERO) || (ops[1].kind == K_ZERO);
        nan_w    = (ops[0].kind inside {K_QNAN, K_SNAN}) ? ops[0].raw : ops[1].raw;
        nan_w[MW-1] = 1'b1;
        inf_w    = {sgn, {EW{1'b1}}, {MW{1'b0}}};
        zero_w   = {sgn, {(FW-1){1'b0}}};
        nxt      = fin_r;
        if (any_nan) begin
            nxt = '{head: nan_w, tail: nan_w,
                    inv: (ops[0].kind == K_SNAN) || (ops[1].kind == K_SNAN),
                    ovf: 1'b0, unf: 1'b0, inx: 1'b0};
        end else if (any_inf && any_zero) begin
            nxt = '{head: QNAN_DEF, tail: QNAN_DEF, inv: 1'b1, ovf: 1'b0, unf: 1'b0, inx: 1'b0};
        end else if (any_inf) begin
            nxt = '{head: inf_w, tail: inf_w, inv: 1'b0, ovf: 1'b0, unf: 1'b0, inx: 1'b0};
        end else if (any_zero) begin
            nxt = '{head: zero_w, tail: zero_w, inv: 1'b0, ovf: 1'b0, unf: 1'b0, inx: 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            r_q       <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) r_q <= nxt;
        end
    end

    assign head           = r_q.head;
    assign tail           = r_q.tail;
    assign flag_invalid   = r_q.inv;
    assign flag_overflow  = r_q.ovf;
    assign flag_underflow = r_q.unf;
    assign flag_inexact   = r_q.inx;

    a_r10_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r10_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid && $stable(head) && $stable(tail));
    a_r3_ovf_inf: assert property (@(posedge clk) disable iff (rst)
        flag_overflow |-> (head == tail) && (head[FW-2:0] == {{EW{1'b1}}, {MW{1'b0}}}) && flag_inexact);
    a_r9_unf_inexact: assert property (@(posedge clk) disable iff (rst)
        flag_underflow |-> flag_inexact && !flag_overflow);
    a_r6_nan_pair: assert property (@(posedge clk) disable iff (rst)
        is_nan(head) |-> (tail == head) && head[MW-1]);
    a_r7_invalid_nan: assert property (@(posedge clk) disable iff (rst)
        flag_invalid |-> is_nan(head));
    a_r2_tail_below_head: assert property (@(posedge clk) disable iff (rst)
        (head[FW-2:MW] != {EW{1'b1}}) && (tail[FW-2:0] != '0) |-> tail[FW-2:MW] < head[FW-2:MW]);
endmodule

// File: tb/sim_twin_product_unit.sv
`timescale 1ns/1ps
module sim_twin_product_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic        out_valid;
    logic [31:0] head, tail;
    logic        flag_invalid, flag_overflow, flag_underflow, flag_inexact;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [31:0] h;
        logic [31:0] t;
        logic [3:0]  f;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    twin_product_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .out_valid(out_valid), .head(head), .tail(tail),
        .flag_invalid(flag_invalid), .flag_overflow(flag_overflow),
        .flag_underflow(flag_underflow), .flag_inexact(flag_inexact));

    task automatic check(input string tag, input logic ok, input logic [95:0] act, input logic [95:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // flags order: {invalid, overflow, underflow, inexact}
    task automatic send(input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] eh, input logic [31:0] et,
                        input logic [3:0] ef, input string tag);
        exp_t e;
        @(negedge clk);
        op_a = a;
        op_b = b;
        in_valid = 1'b1;
        e.h = eh; e.t = et; e.f = ef; e.tag = tag;
        sb.push_back(e);
    endtask

    // Reference for normal operands: integer exact product, nearest with ties toward zero
    function automatic logic [63:0] ref_pair(input logic s, input int ea, input int eb,
                                             input logic [23:0] sa, input logic [23:0] sbig);
        logic [63:0] qv, r, hm, tm, tn;
        int sh, hexp, k, tf;
        logic up;
        logic [31:0] hw, tw;
        qv   = 64'(sa) * 64'(sbig);
        sh   = qv[47] ? 24 : 23;
        hm   = qv >> sh;
        r    = qv & ((64'd1 << sh) - 1);
        up   = r > (64'd1 << (sh - 1));
        hexp = ea + eb - 127 + (qv[47] ? 1 : 0);
        tm   = up ? ((64'd1 << sh) - r) : r;
        if (up) hm = hm + 1;
        if (hm == (64'd1 << 24)) begin hm = 64'd1 << 23; hexp++; end
        hw = {s, hexp[7:0], hm[22:0]};
        if (tm == 0) tw = {s, 31'd0};
        else begin
            k = 0;
            for (int i = 0; i < 48; i++) if (tm[i]) k = i;
            tf = ea + eb - 173 + k;
            tn = tm << (23 - k);
            tw = {s ^ up, tf[7:0], tn[22:0]};
        end
        return {hw, tw};
    endfunction

    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (sb.size() == 0) begin
                check("R10 unexpected result", 1'b0, {head, tail, 28'd0, flag_invalid, flag_overflow, flag_underflow, flag_inexact}, '0);
            end else begin
                exp_t e;
                logic [3:0] fl;
                e  = sb.pop_front();
                fl = {flag_invalid, flag_overflow, flag_underflow, flag_inexact};
                check(e.tag, (head == e.h) && (tail == e.t) && (fl == e.f),
                      {head, tail, 28'd0, fl}, {e.h, e.t, 28'd0, e.f});
            end
        end
    end

    initial begin
        repeat (60000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [63:0] pr;
        int seed;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R10 reset valid", out_valid == 1'b0, {95'd0, out_valid}, '0);
        check("R10 reset head/tail", (head == 0) && (tail == 0), {head, tail, 32'd0}, '0);
        check("R10 reset flags", {flag_invalid, flag_overflow, flag_underflow, flag_inexact} == 4'b0,
              {92'd0, flag_invalid, flag_overflow, flag_underflow, flag_inexact}, '0);

        send(32'h3FC00000, 32'h3F800001, 32'h3FC00001, 32'h33800000, 4'b0000, "R1 tie toward zero");
        send(32'h40400000, 32'h40A00000, 32'h41700000, 32'h00000000, 4'b0000, "R2 exact 3*5");
        send(32'h7F000000, 32'h3F800000, 32'h7F000000, 32'h00000000, 4'b0000, "R2 large exact");
        send(32'h7F000000, 32'h40000000, 32'h7F800000, 32'h7F800000, 4'b0101, "R3 overflow pos");
        send(32'h7F000000, 32'hC0000000, 32'hFF800000, 32'hFF800000, 4'b0101, "R3 overflow neg");
        send(32'h7F800000, 32'hFF800000, 32'hFF800000, 32'hFF800000, 4'b0000, "R4 inf*-inf");
        send(32'hFF800000, 32'h40000000, 32'hFF800000, 32'hFF800000, 4'b0000, "R4 -inf*2");
        send(32'h00000000, 32'h80000000, 32'h80000000, 32'h80000000, 4'b0000, "R5 +0*-0");
        send(32'h80000000, 32'h80000000, 32'h00000000, 32'h00000000, 4'b0000, "R5 -0*-0");
        send(32'h80000000, 32'h3F800000, 32'h80000000, 32'h80000000, 4'b0000, "R5 -0*1");
        send(32'h7F800001, 32'h3F800000, 32'h7FC00001, 32'h7FC00001, 4'b1000, "R6 sNaN a");
        send(32'h3F800000, 32'hFFC00005, 32'hFFC00005, 32'hFFC00005, 4'b0000, "R6 qNaN b");
        send(32'h7F800001, 32'h7FC00000, 32'h7FC00001, 32'h7FC00001, 4'b1000, "R6 both NaN");
        send(32'h00000000, 32'hFF800000, 32'h7FC00000, 32'h7FC00000, 4'b1000, "R7 zero*inf");
        send(32'h00000001, 32'h3F000000, 32'h00000000, 32'h00000000, 4'b0011, "R8 subnormal tie to zero");
        send(32'h00000003, 32'h3F000000, 32'h00000001, 32'h00000000, 4'b0011, "R8 subnormal tie 1.5");
        send(32'h00800001, 32'h3F800001, 32'h00800002, 32'h00000000, 4'b0011, "R9 tail lost");
        send(32'h00000002, 32'h3F000000, 32'h00000001, 32'h00000000, 4'b0000, "R9 exact subnormal");

        seed = 32'h1234567;
        for (int n = 0; n < 40; n++) begin
            logic [23:0] sa, sbg;
            int ea, eb;
            logic s1, s2;
            seed = seed ^ (seed << 13); seed = seed ^ (seed >>> 17); seed = seed ^ (seed << 5);
            sa  = 24'h800000 | (seed[22:0] & 23'h7FFFFC) | 24'd3;
            seed = seed ^ (seed << 13); seed = seed ^ (seed >>> 17); seed = seed ^ (seed << 5);
            sbg = 24'h800000 | (seed[22:0] & 23'h7FFFFC) | 24'd3;
            ea  = 110 + (n % 35);
            eb  = 144 - (n % 29);
            s1  = n[0];
            s2  = n[1];
            pr  = ref_pair(s1 ^ s2, ea, eb, sa, sbg);
            send({s1, ea[7:0], sa[22:0]}, {s2, eb[7:0], sbg[22:0]}, pr[63:32], pr[31:0], 4'b0000,
                 "R2 R1 low-bits-set product");
        end

        @(negedge clk);
        in_valid = 1'b0;
        op_a = 32'h3F800000;
        op_b = 32'h3F800000;
        repeat (3) @(negedge clk);
        check("R10 hold when idle", (out_valid == 1'b0) && (head == pr[63:32]),
              {63'd0, out_valid, head}, {64'd0, pr[63:32]});
        check("R10 drained", sb.size() == 0, 96'(sb.size()), '0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule